// File: doc/BRIEF.md
# Display Power Sequencer

This block brings a graphic LCD controller from power-on to an operating display and later takes it back to a safe state for supply removal. On a start-up trigger it pulses the controller's active-low reset, waits, and then streams the configuration command bytes to a bus master through a request/acknowledge port. On a shut-down trigger it stops the display, discharges the drive capacitors and counts the minimum settling time before reporting completion.

Every command byte carries an opcode in bits 7..4 and a 4-bit argument in bits 3..0. Opcodes are decoded within a register bank, so the sequencer tracks the bank the controller currently has selected. It inserts a bank-select byte only where the next command needs a different bank, or where the bank is unknown after a controller reset. Values wider than four bits go out as a low-nibble command followed by a high-nibble command.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After system reset, `lcd_rst_n` is 1, and `cmd_req`, `ready` and `done` are 0.
- R2: A start-up trigger drives `lcd_rst_n` low for exactly RST_CYC cycles. It then holds `lcd_rst_n` high for exactly WAIT_CYC cycles before the first `cmd_req`. No request is made while `lcd_rst_n` is low.
- R3: A bank-select byte is 0xF0 with the bank number in bits 2..0 and bit 3 at 0. Every other byte is the opcode in bits 7..4 and the argument in bits 3..0.
- R4: The start-up stream, without selects, is: volume low 0xA and high 0xB in bank 4, where the high nibble is {0,vol[6:4]}. Then, in bank 0: bias 0xE {0,bias}, boost 0xD {0,boost}, line-inversion count 0x6 low and 0x7 high, and power control 0xBA (op-amp on and booster on). Then start line 0x4 low and 0x5 high, increment mode 0xA1, X address 0x00 and 0x10, Y address 0x20 and 0x30, duty 0xC {duty}, and display on 0x81.
- R5: A bank-select byte is sent only when the next command's bank differs from the tracked bank, or when the bank is unknown. The bank is unknown after system reset and after each controller reset.
- R6: `cmd_req` stays high and `cmd_byte` stays stable until `cmd_ack` is sampled high. The sequencer advances one byte for each acknowledged cycle.
- R7: After the final start-up byte is acknowledged, `done` is high for exactly one cycle, in the next cycle, and `ready` becomes 1 at the same time.
- R8: A shut-down trigger clears `ready`. It then sends halt 0xB4 in bank 0 and discharge 0xE1 in bank 4. It counts DISCH_CYC cycles after the discharge byte is acknowledged and then pulses `done`.
- R9: Triggers arriving while a sequence runs are ignored. If both triggers arrive together in idle, start-up wins.
- R10: The configuration inputs are captured at the start-up trigger. Later changes do not alter the bytes of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| start_up | input | 1 | Start-up trigger |
| start_down | input | 1 | Shut-down trigger |
| cfg_vol | input | 7 | Contrast volume |
| cfg_bias | input | 3 | Bias ratio code |
| cfg_boost | input | 3 | Boost factor code |
| cfg_ninv | input | 8 | Line-inversion count |
| cfg_duty | input | 4 | Duty code |
| cfg_line | input | 8 | Display start line |
| lcd_rst_n | output | 1 | Controller reset, active low |
| cmd_req | output | 1 | Command byte valid, request to bus master |
| cmd_byte | output | 8 | Command byte |
| cmd_ack | input | 1 | Bus master accepts the byte this cycle |
| ready | output | 1 | Display is initialised |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
On every cycle, the assertions check the handshake hold rule and the absence of requests during controller reset. They also check that no redundant bank select is sent, that the done pulse lasts one cycle, and that `ready` and requests never overlap. Only the bench scenarios can show the exact byte order and values and the reset and wait lengths. The same holds for the discharge delay, the capture of the configuration, and the ignoring of triggers mid-sequence. The bench compares every acknowledged byte against a stream it builds from the requirements.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int VOL_W  = 7;
  localparam int CODE_W = 3;
  localparam int LINE_W = 8;
  localparam int DUTY_W = 4;
  localparam int BANK_W = 3;
  localparam int IDX_W  = 4;

  localparam logic [3:0] OP_BANK    = 4'hF;
  localparam logic [3:0] OP_VOL_LO  = 4'hA;
  localparam logic [3:0] OP_VOL_HI  = 4'hB;
  localparam logic [3:0] OP_BIAS    = 4'hE;
  localparam logic [3:0] OP_BOOST   = 4'hD;
  localparam logic [3:0] OP_NINV_LO = 4'h6;
  localparam logic [3:0] OP_NINV_HI = 4'h7;
  localparam logic [3:0] OP_PWR     = 4'hB;
  localparam logic [3:0] OP_LINE_LO = 4'h4;
  localparam logic [3:0] OP_LINE_HI = 4'h5;
  localparam logic [3:0] OP_INC     = 4'hA;
  localparam logic [3:0] OP_X_LO    = 4'h0;
  localparam logic [3:0] OP_X_HI    = 4'h1;
  localparam logic [3:0] OP_Y_LO    = 4'h2;
  localparam logic [3:0] OP_Y_HI    = 4'h3;
  localparam logic [3:0] OP_DUTY    = 4'hC;
  localparam logic [3:0] OP_DISP    = 4'h8;
  localparam logic [3:0] OP_DISCH   = 4'hE;

  // power control argument bits: op-amp, halt, booster, controller clear
  localparam logic [3:0] PWR_AMP   = 4'b1000;
  localparam logic [3:0] PWR_HALT  = 4'b0100;
  localparam logic [3:0] PWR_BOOST = 4'b0010;

  localparam logic [BANK_W-1:0] BANK_MAIN = 3'd0;
  localparam logic [BANK_W-1:0] BANK_AUX  = 3'd4;

  typedef struct packed {
    logic [VOL_W-1:0]  vol;
    logic [CODE_W-1:0] bias;
    logic [CODE_W-1:0] boost;
    logic [LINE_W-1:0] ninv;
    logic [DUTY_W-1:0] duty;
    logic [LINE_W-1:0] sline;
  } seq_cfg_t;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [7:0]        code;
    logic              last;
  } seq_step_t;

  typedef enum logic [2:0] {S_IDLE, S_RST_LO, S_RST_WAIT, S_CMD, S_DWAIT} seq_state_e;

  function automatic logic [7:0] mk_cmd(logic [3:0] op, logic [3:0] arg);
    return {op, arg};
  endfunction

  function automatic logic [7:0] bank_sel(logic [BANK_W-1:0] b);
    return {OP_BANK, 1'b0, b};
  endfunction

  function automatic seq_step_t step_of(logic down, logic [IDX_W-1:0] idx, seq_cfg_t c);
    seq_step_t s;
    s.bank = BANK_MAIN;
    s.last = 1'b0;
    s.code = 8'h00;
    if (down) begin
      if (idx == '0) s.code = mk_cmd(OP_PWR, PWR_HALT);
      else begin
        s.bank = BANK_AUX;
        s.code = mk_cmd(OP_DISCH, 4'h1);
        s.last = 1'b1;
      end
    end else begin
      case (idx)
        4'd0:  begin s.bank = BANK_AUX; s.code = mk_cmd(OP_VOL_LO, c.vol[3:0]); end
        4'd1:  begin s.bank = BANK_AUX; s.code = mk_cmd(OP_VOL_HI, {1'b0, c.vol[6:4]}); end
        4'd2:  s.code = mk_cmd(OP_BIAS, {1'b0, c.bias});
        4'd3:  s.code = mk_cmd(OP_BOOST, {1'b0, c.boost});
        4'd4:  s.code = mk_cmd(OP_NINV_LO, c.ninv[3:0]);
        4'd5:  s.code = mk_cmd(OP_NINV_HI, c.ninv[7:4]);
        4'd6:  s.code = mk_cmd(OP_PWR, PWR_AMP | PWR_BOOST);
        4'd7:  s.code = mk_cmd(OP_LINE_LO, c.sline[3:0]);
        4'd8:  s.code = mk_cmd(OP_LINE_HI, c.sline[7:4]);
        4'd9:  s.code = mk_cmd(OP_INC, 4'h1);
        4'd10: s.code = mk_cmd(OP_X_LO, 4'h0);
        4'd11: s.code = mk_cmd(OP_X_HI, 4'h0);
        4'd12: s.code = mk_cmd(OP_Y_LO, 4'h0);
        4'd13: s.code = mk_cmd(OP_Y_HI, 4'h0);
        4'd14: s.code = mk_cmd(OP_DUTY, c.duty);
        default: begin s.code = mk_cmd(OP_DISP, 4'h1); s.last = 1'b1; end
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/seq_rom.sv
module seq_rom
  import lcd_seq_pkg::*;
(
  input  logic                 down,
  input  logic [IDX_W-1:0]     idx,
  input  seq_cfg_t             cfg,
  output seq_step_t            step
);
  always_comb step = step_of(down, idx, cfg);
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= len;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == CW'(1));

  a_r2_tick_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick || $past(load));
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_seq_pkg::*;
#(
  parameter int RST_CYC   = 2500,
  parameter int WAIT_CYC  = 25000,
  parameter int DISCH_CYC = 5000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_up,
  input  logic               start_down,
  input  logic [VOL_W-1:0]   cfg_vol,
  input  logic [CODE_W-1:0]  cfg_bias,
  input  logic [CODE_W-1:0]  cfg_boost,
  input  logic [LINE_W-1:0]  cfg_ninv,
  input  logic [DUTY_W-1:0]  cfg_duty,
  input  logic [LINE_W-1:0]  cfg_line,
  output logic               lcd_rst_n,
  output logic               cmd_req,
  output logic [7:0]         cmd_byte,
  input  logic               cmd_ack,
  output logic               ready,
  output logic               done
);
  localparam int MAX_A   = (RST_CYC > WAIT_CYC) ? RST_CYC : WAIT_CYC;
  localparam int MAX_CYC = (MAX_A > DISCH_CYC) ? MAX_A : DISCH_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] RST_LEN   = CW'(RST_CYC);
  localparam logic [CW-1:0] WAIT_LEN  = CW'(WAIT_CYC);
  localparam logic [CW-1:0] DISCH_LEN = CW'(DISCH_CYC);

  seq_state_e        st;
  logic [IDX_W-1:0]  idx;
  logic              down_q;
  seq_cfg_t          cfg_q;
  logic [BANK_W-1:0] bank_q;
  logic              bank_vld;
  seq_step_t         step;

  // named events for assertions and readability
  logic need_sel, xfer, seq_end, tm_load, tm_tick;
  logic [CW-1:0] tm_len;

  seq_rom u_rom (.down(down_q), .idx(idx), .cfg(cfg_q), .step(step));

  seq_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .len(tm_len), .tick(tm_tick));

  always_comb begin
    need_sel  = !bank_vld || (bank_q != step.bank);
    cmd_req   = (st == S_CMD);
    cmd_byte  = need_sel ? bank_sel(step.bank) : step.code;
    xfer      = cmd_req && cmd_ack;
    seq_end   = xfer && !need_sel && step.last;
    lcd_rst_n = (st != S_RST_LO);
    tm_load   = 1'b0;
    tm_len    = RST_LEN;
    if (st == S_IDLE && start_up) begin
      tm_load = 1'b1;
    end else if (st == S_RST_LO && tm_tick) begin
      tm_load = 1'b1;
      tm_len  = WAIT_LEN;
    end else if (seq_end && down_q) begin
      tm_load = 1'b1;
      tm_len  = DISCH_LEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      down_q   <= 1'b0;
      cfg_q    <= '0;
      bank_q   <= '0;
      bank_vld <= 1'b0;
      ready    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          idx <= '0;
          if (start_up) begin
            st       <= S_RST_LO;
            down_q   <= 1'b0;
            ready    <= 1'b0;
            bank_vld <= 1'b0;
            cfg_q    <= '{vol: cfg_vol, bias: cfg_bias, boost: cfg_boost,
                          ninv: cfg_ninv, duty: cfg_duty, sline: cfg_line};
          end else if (start_down) begin
            st     <= S_CMD;
            down_q <= 1'b1;
            ready  <= 1'b0;
          end
        end
        S_RST_LO:   if (tm_tick) st <= S_RST_WAIT;
        S_RST_WAIT: if (tm_tick) st <= S_CMD;
        S_CMD: begin
          if (xfer) begin
            if (need_sel) begin
              bank_q   <= step.bank;
              bank_vld <= 1'b1;
            end else if (step.last) begin
              if (down_q) st <= S_DWAIT;
              else begin
                st    <= S_IDLE;
                ready <= 1'b1;
                done  <= 1'b1;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_DWAIT: if (tm_tick) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_byte)));

  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n |-> !cmd_req);

  a_r5_no_redundant_select: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cmd_byte[7:4] == OP_BANK) |-> !(bank_vld && bank_q == cmd_byte[2:0]));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_ready_excludes_req: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !cmd_req);

  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_req && lcd_rst_n);
endmodule

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb;
  localparam int RC = 5, WC = 7, DC = 40;

  logic clk = 0, rst_n = 0, start_up = 0, start_down = 0, cmd_ack = 0;
  logic [6:0] cfg_vol = 0;
  logic [2:0] cfg_bias = 0, cfg_boost = 0;
  logic [7:0] cfg_ninv = 0, cfg_line = 0;
  logic [3:0] cfg_duty = 0;
  logic lcd_rst_n, cmd_req, ready, done;
  logic [7:0] cmd_byte;

  int checks = 0, errors = 0, cyc = 0, last_ack_cyc = 0, lo_total = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcd_pwr_seq #(.RST_CYC(RC), .WAIT_CYC(WC), .DISCH_CYC(DC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_up(start_up), .start_down(start_down),
    .cfg_vol(cfg_vol), .cfg_bias(cfg_bias), .cfg_boost(cfg_boost),
    .cfg_ninv(cfg_ninv), .cfg_duty(cfg_duty), .cfg_line(cfg_line),
    .lcd_rst_n(lcd_rst_n), .cmd_req(cmd_req), .cmd_byte(cmd_byte),
    .cmd_ack(cmd_ack), .ready(ready), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // R3: selects are 0xF0|bank, commands are {op,arg}
  function automatic void push_up(logic [6:0] v, logic [2:0] bi, logic [2:0] bo,
                                  logic [7:0] n, logic [3:0] du, logic [7:0] sl);
    exp_q.push_back(8'hF4);
    exp_q.push_back({4'hA, v[3:0]});
    exp_q.push_back({4'hB, 1'b0, v[6:4]});
    exp_q.push_back(8'hF0);
    exp_q.push_back({4'hE, 1'b0, bi});
    exp_q.push_back({4'hD, 1'b0, bo});
    exp_q.push_back({4'h6, n[3:0]});
    exp_q.push_back({4'h7, n[7:4]});
    exp_q.push_back(8'hBA);
    exp_q.push_back({4'h4, sl[3:0]});
    exp_q.push_back({4'h5, sl[7:4]});
    exp_q.push_back(8'hA1);
    exp_q.push_back(8'h00);
    exp_q.push_back(8'h10);
    exp_q.push_back(8'h20);
    exp_q.push_back(8'h30);
    exp_q.push_back({4'hC, du});
    exp_q.push_back(8'h81);
  endfunction

  // scoreboard monitor and acknowledging bus master with varying latency
  int wcnt = 0, dly = 0;
  logic [7:0] first_byte;
  always @(negedge clk) begin
    if (rst_n && !lcd_rst_n) lo_total++;
    cmd_ack <= 1'b0;
    if (rst_n && cmd_req && !cmd_ack) begin
      if (wcnt == 0) first_byte = cmd_byte;
      if (wcnt >= dly) begin
        logic [7:0] e;
        chk(cmd_byte == first_byte, "R6 byte held", cmd_byte, first_byte);
        if (exp_q.size() == 0) chk(0, "R4,R5 unexpected byte", cmd_byte, 0);
        else begin
          e = exp_q.pop_front();
          chk(cmd_byte == e, "R3,R4,R5 byte", cmd_byte, e);
          if (exp_q.size() == 0) last_ack_cyc = cyc;
        end
        cmd_ack <= 1'b1;
        wcnt = 0;
        dly = (dly + 1) % 4;
      end else wcnt++;
    end
  end

  task automatic wait_done(output int at);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    at = cyc;
  endtask

  task automatic run_up(input bit both, input bit disturb);
    int lo = 0, hi = 0, at, lo0;
    logic [6:0] v = cfg_vol;
    lo0 = lo_total;
    push_up(cfg_vol, cfg_bias, cfg_boost, cfg_ninv, cfg_duty, cfg_line);
    @(negedge clk); start_up = 1; start_down = both;
    @(negedge clk); start_up = 0; start_down = 0;
    while (!lcd_rst_n) begin lo++; @(negedge clk); end
    chk(lo == RC, "R2 reset low length", lo, RC);
    while (!cmd_req) begin hi++; @(negedge clk); end
    chk(hi == WC, "R2 post-reset wait", hi, WC);
    if (disturb) begin
      // R10: change config, R9: triggers while busy
      cfg_vol = ~v; cfg_bias = 3'd7; cfg_ninv = 8'h00; cfg_line = 8'hFF; cfg_duty = 4'h0;
      start_up = 1; start_down = 1;
      @(negedge clk); start_up = 0; start_down = 0;
    end
    wait_done(at);
    chk(at == last_ack_cyc + 1, "R7 done timing", at, last_ack_cyc + 1);
    chk(ready == 1, "R7 ready set", ready, 1);
    chk(exp_q.size() == 0, "R4 stream complete", exp_q.size(), 0);
    chk(lo_total - lo0 == RC, "R9 no second reset", lo_total - lo0, RC);
    @(negedge clk);
    chk(done == 0, "R7 done one cycle", done, 0);
  endtask

  task automatic run_down(input bit bank_main_known);
    int at;
    if (!bank_main_known) exp_q.push_back(8'hF0);
    exp_q.push_back(8'hB4);
    exp_q.push_back(8'hF4);
    exp_q.push_back(8'hE1);
    @(negedge clk); start_down = 1;
    @(negedge clk); start_down = 0;
    chk(ready == 0, "R8 ready cleared", ready, 0);
    wait_done(at);
    chk(at == last_ack_cyc + 1 + DC, "R8 discharge wait", at, last_ack_cyc + 1 + DC);
    chk(exp_q.size() == 0, "R8,R5 down stream", exp_q.size(), 0);
    chk(lcd_rst_n == 1, "R8 no reset on down", lcd_rst_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(lcd_rst_n == 1, "R1 lcd_rst_n", lcd_rst_n, 1);
    chk(cmd_req == 0, "R1 cmd_req", cmd_req, 0);
    chk(ready == 0, "R1 ready", ready, 0);
    chk(done == 0, "R1 done", done, 0);
    // R5: bank unknown after reset, select precedes halt
    run_down(0);
    cfg_vol = 7'h5A; cfg_bias = 3'd3; cfg_boost = 3'd5;
    cfg_ninv = 8'hC3; cfg_duty = 4'h9; cfg_line = 8'h2E;
    run_up(0, 0);
    // R5: bank 0 known, halt goes without select
    run_down(1);
    // R9: simultaneous triggers, start-up wins; R10 captured config
    cfg_vol = 7'h27; cfg_bias = 3'd1; cfg_boost = 3'd6;
    cfg_ninv = 8'h5E; cfg_duty = 4'hF; cfg_line = 8'h9B;
    run_up(1, 1);
    repeat (5) @(negedge clk);
    chk(cmd_req == 0, "R9 idle after sequence", cmd_req, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule